// File: doc/BRIEF.md
# Shared Counter with Per-Processor Compare

This block keeps one 32-bit counter shared by a group of processors. The counter advances by one every clock and wraps to zero. A stop bit in a shared configuration register freezes it. While the counter is frozen, software may load a new count. Each processor owns a compare register. When the counter steps onto that value, the processor's compare-pending bit is set and stays set until the compare register is written again.

Each processor also has a mask bit for its compare event and a routing word. The routing word holds a route-enable flag and a pin number. A pending compare event that is unmasked and routed raises one request line for that processor at once. The count can be read through a privileged word and through a read-only user alias. The upper counter word always reads zero.

Registers sit on a simple word-addressed port. Reads are combinational. Writes take effect on the rising clock edge. For the per-processor registers, `cpu_sel` chooses the processor being accessed.

Top module: `shared_cmp_timer`

## Requirements
- R1: After reset the counter is 0 and running, and every compare register is 0xFFFFFFFF. Every compare mask is enabled, and every routing word has route-enable set and pin 0. Every pending bit is clear.
- R2: While running, the counter advances by exactly 1 each clock and wraps from 0xFFFFFFFF to 0. It is read at word address 1.
- R3: Bit 24 of the configuration word (address 0) is the stop bit. Writing 1 freezes the counter from the next clock, and writing 0 resumes it.
- R4: A write to address 1 loads the counter only while the counter is stopped. While it is running, the write is ignored.
- R5: Address 2 (upper counter word) and address 9 (user upper alias) read 0. Address 8 (user lower alias) reads the counter, and writes to addresses 8 and 9 change nothing.
- R6: The configuration word reads the processor count in bits [7:0] and (source count / 8) - 1 in bits [15:8]. The counter-width field in bits [23:16] reads 0, and bit 24 reads the live stop bit.
- R7: The pending bit of a processor is set on the clock where a running counter steps to that processor's compare value (address 3).
- R8: A pending bit stays set until the compare register of that processor is written, and that write clears it. When the write and a match fall on the same clock, the write wins.
- R9: Writing 1 in bit 0 of address 5 enables the selected processor's compare mask, and writing 1 in bit 0 of address 6 disables it. Address 7 reads bit 0 = pending and bit 1 = mask.
- R10: The routing word at address 4 holds route-enable in bit 31 and the pin number in bits [2:0]. Request line `pin_req[p*8+pin]` is high exactly when processor p is pending, unmasked and routed, and no other line of p is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | SEL_W | Processor whose local registers are accessed |
| addr | input | 4 | Word address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| cmp_pend | output | NUM_PROCS | Compare-pending bit of each processor |
| pin_req | output | NUM_PROCS*NUM_PINS | Pin requests, NUM_PINS lines per processor |

## Verification
The hardest cases to reach are a match on the exact clock that also carries a compare write, and a match across the counter wrap. A free-running counter cannot be aimed at from outside.

The stimulus therefore stops the counter, loads a chosen count and writes a compare value a few steps ahead, then releases the stop bit. Each later clock edge then has a known counter value. The bench can place the compare rewrite on the clock where the match would occur, and it can load 0xFFFFFFFE to observe the wrap to 0 matching a compare of 0.

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer #(
  parameter int NUM_PROCS = 2,
  parameter int NUM_SRCS  = 32,
  parameter int NUM_PINS  = 8,
  localparam int SEL_W = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEL_W-1:0]              cpu_sel,
  input  logic [3:0]                    addr,
  input  logic                          wr_en,
  input  logic [31:0]                   wr_data,
  output logic [31:0]                   rd_data,
  output logic [NUM_PROCS-1:0]          cmp_pend,
  output logic [NUM_PROCS*NUM_PINS-1:0] pin_req
);
  localparam logic [3:0] A_CFG = 4'd0, A_CNT = 4'd1, A_CNTH = 4'd2, A_CMP = 4'd3,
                         A_MAP = 4'd4, A_MSET = 4'd5, A_MCLR = 4'd6, A_STAT = 4'd7,
                         A_UCNT = 4'd8, A_UCNTH = 4'd9;
  localparam int STOP_BIT = 24;
  localparam logic [7:0] PROC_FLD = 8'(NUM_PROCS);
  localparam logic [7:0] SRC_FLD  = 8'(NUM_SRCS / 8 - 1);

  logic [31:0]      count_q;
  logic             stop_q;
  logic [31:0]      cnt_inc;
  logic [31:0]      cmp_q   [NUM_PROCS];
  logic [PIN_W-1:0] pin_q   [NUM_PROCS];
  logic [NUM_PROCS-1:0] pend_q, mask_q, route_q;

  assign cnt_inc  = count_q + 32'd1;
  assign cmp_pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      stop_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_CFG) stop_q <= wr_data[STOP_BIT];
      if (!stop_q)                         count_q <= cnt_inc;
      else if (wr_en && addr == A_CNT)     count_q <= wr_data;
    end
  end

  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_proc
    logic sel_p;
    assign sel_p = wr_en && (cpu_sel == SEL_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[p]   <= '1;
        pend_q[p]  <= 1'b0;
        mask_q[p]  <= 1'b1;
        route_q[p] <= 1'b1;
        pin_q[p]   <= '0;
      end else begin
        if (sel_p && addr == A_CMP) begin
          cmp_q[p]  <= wr_data;
          pend_q[p] <= 1'b0;
        end else if (!stop_q && cnt_inc == cmp_q[p]) begin
          pend_q[p] <= 1'b1;
        end
        if (sel_p && addr == A_MAP) begin
          route_q[p] <= wr_data[31];
          pin_q[p]   <= wr_data[PIN_W-1:0];
        end
        if (sel_p && addr == A_MSET && wr_data[0]) mask_q[p] <= 1'b1;
        if (sel_p && addr == A_MCLR && wr_data[0]) mask_q[p] <= 1'b0;
      end
    end

    assign pin_req[p*NUM_PINS +: NUM_PINS] =
      (pend_q[p] && mask_q[p] && route_q[p]) ? (NUM_PINS'(1) << pin_q[p]) : '0;

    // R7
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[p]) |-> ($past(!stop_q) && count_q == cmp_q[p]));
    // R8
    cmp_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMP && cpu_sel == SEL_W'(p)) |=> !cmp_pend[p]);
    // R10
    one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pin_req[p*NUM_PINS +: NUM_PINS]));
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CFG:          rd_data = {7'd0, stop_q, 8'd0, SRC_FLD, PROC_FLD};
      A_CNT, A_UCNT:  rd_data = count_q;
      A_CMP:          rd_data = cmp_q[cpu_sel];
      A_MAP:          rd_data = {route_q[cpu_sel], {(31-PIN_W){1'b0}}, pin_q[cpu_sel]};
      A_STAT:         rd_data = {30'd0, mask_q[cpu_sel], pend_q[cpu_sel]};
      default:        rd_data = '0;
    endcase
  end

  // R2
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_q |=> count_q == $past(count_q) + 32'd1);
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !(wr_en && addr == A_CNT)) |=> $stable(count_q));
  // R4
  run_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_q && wr_en && addr == A_CNT) |=> count_q == $past(count_q) + 32'd1);
endmodule

// File: tb/shared_cmp_timer_tb.sv
module shared_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:0]  cpu_sel = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  cmp_pend;
  logic [15:0] pin_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shared_cmp_timer dut_i (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cmp_pend(cmp_pend), .pin_req(pin_req));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd1, d); chk("R1 count at reset", d, 32'd0);
    rd(4'd0, d); chk("R6 config fields", d, 32'h0000_0302);
    cpu_sel = 1'b1;
    rd(4'd3, d); chk("R1 compare reset", d, 32'hFFFF_FFFF);
    rd(4'd4, d); chk("R1 map reset", d, 32'h8000_0000);
    rd(4'd7, d); chk("R1 mask on, pend off", d, 32'd2);
    cpu_sel = 1'b0;
    chk("R1 no pending", {30'd0, cmp_pend}, 32'd0);
    @(negedge clk);
    rd(4'd1, d); chk("R2 first step", d, 32'd1);
  endtask

  task automatic t_stop_write();
    logic [31:0] c, d;
    rd(4'd1, c);
    wr(4'd1, 32'hDEAD_0000);
    rd(4'd1, d); chk("R4 running write ignored", d, c + 32'd1);
    wr(4'd0, 32'h0100_0000);
    rd(4'd1, c);
    repeat (3) @(negedge clk);
    rd(4'd1, d); chk("R3 stopped holds", d, c);
    wr(4'd1, 32'h100);
    rd(4'd1, d); chk("R4 stopped write loads", d, 32'h100);
    rd(4'd2, d); chk("R5 upper word zero", d, 32'd0);
    rd(4'd9, d); chk("R5 user upper zero", d, 32'd0);
    rd(4'd8, d); chk("R5 user alias reads count", d, 32'h100);
    wr(4'd8, 32'h55);
    wr(4'd9, 32'h66);
    rd(4'd1, d); chk("R5 user writes ignored", d, 32'h100);
    rd(4'd0, d); chk("R6 stop bit visible", d, 32'h0100_0302);
  endtask

  task automatic t_match();
    cpu_sel = 1'b0;
    wr(4'd3, 32'h105);
    wr(4'd0, 32'h0);
    repeat (4) @(negedge clk);
    chk("R7 no early pending", {31'd0, cmp_pend[0]}, 32'd0);
    @(negedge clk);
    chk("R7 pending on match", {31'd0, cmp_pend[0]}, 32'd1);
    chk("R10 reset route pin0", {16'd0, pin_req}, 32'h0001);
    chk("R7 other cpu unaffected", {31'd0, cmp_pend[1]}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R8 pending sticky", {31'd0, cmp_pend[0]}, 32'd1);
    wr(4'd3, 32'h105);
    chk("R8 compare write clears", {31'd0, cmp_pend[0]}, 32'd0);
    chk("R10 request drops", {16'd0, pin_req}, 32'd0);
  endtask

  task automatic t_routing();
    logic [31:0] d;
    wr(4'd0, 32'h0100_0000);
    wr(4'd1, 32'h200);
    cpu_sel = 1'b1;
    wr(4'd4, 32'h8000_0003);
    wr(4'd6, 32'h1);
    wr(4'd3, 32'h202);
    wr(4'd0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R7 cpu1 pending", {30'd0, cmp_pend}, 32'd2);
    chk("R9 masked no request", {16'd0, pin_req}, 32'd0);
    rd(4'd4, d); chk("R10 map readback", d, 32'h8000_0003);
    rd(4'd7, d); chk("R9 status masked pending", d, 32'd1);
    wr(4'd5, 32'h1);
    chk("R9 unmask raises pin3", {16'd0, pin_req}, 32'h0800);
    wr(4'd4, 32'h0000_0003);
    chk("R10 unrouted no request", {16'd0, pin_req}, 32'd0);
    wr(4'd4, 32'h8000_0006);
    chk("R10 pin6 request", {16'd0, pin_req}, 32'h4000);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(4'd0, 32'h0100_0000);
    wr(4'd1, 32'hFFFF_FFFE);
    cpu_sel = 1'b1;
    wr(4'd3, 32'h0);
    wr(4'd0, 32'h0);
    @(negedge clk);
    rd(4'd1, d); chk("R2 before wrap", d, 32'hFFFF_FFFF);
    chk("R7 no pend before wrap", {31'd0, cmp_pend[1]}, 32'd0);
    @(negedge clk);
    rd(4'd1, d); chk("R2 wrapped to zero", d, 32'd0);
    chk("R7 match at zero", {31'd0, cmp_pend[1]}, 32'd1);
  endtask

  task automatic t_write_wins();
    wr(4'd0, 32'h0100_0000);
    wr(4'd1, 32'h300);
    cpu_sel = 1'b0;
    wr(4'd3, 32'h302);
    wr(4'd0, 32'h0);
    @(negedge clk);
    wr(4'd3, 32'h302);
    chk("R8 write wins over match", {31'd0, cmp_pend[0]}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 stays clear", {31'd0, cmp_pend[0]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stop_write();
    t_match();
    t_routing();
    t_wrap();
    t_write_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule